// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block connects a synchronous host to a 1M x 16 asynchronous DRAM with extended data output. The host presents a 20-bit word address, write data, two byte enables and a read/write flag, holding the request until the controller accepts it. The controller sends the upper ten address bits on the shared address pins when the row strobe falls. It sends the lower ten bits when a column strobe falls. It sequences the row strobe, the two byte-lane column strobes, the write strobe and the output enable so that every analog minimum is met as a whole number of clock cycles.

After an access the row stays open. A later request to the same row skips activation and runs only a column cycle. A request to another row first precharges and then activates. The open row is closed on its own before the longest legal row-strobe low time runs out. A separate refresh scheduler can ask for the pins through a grant input. The controller closes any open row, stalls the host and raises an acknowledge until the grant drops.

Read data is sampled a fixed number of cycles after the column strobe falls and is returned with a one-cycle valid pulse.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After a synchronous reset, dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n and dram_oe_n are all 1, dram_dq_oe is 0, and rd_valid and ref_ack are 0.
- R2: dram_addr carries req_addr[19:10] (the row) in the cycle in which dram_ras_n falls, and req_addr[9:0] (the column) in the cycle in which a column strobe falls, so that stored data is returned from the same 20-bit address it was written to.
- R3: On a write, dram_ucas_n (data bits 15:8) falls only if req_be[1] is 1, and dram_lcas_n (bits 7:0) falls only if req_be[0] is 1. A read drives both column strobes low.
- R4: On a write, dram_we_n is 0 in the cycle before a column strobe falls and in the cycle of that fall, with dram_dq_oe 1. dram_dq_oe is never 1 while dram_oe_n is 0.
- R5: Before every fall, dram_ras_n stays high for at least ceil(25 ns / clock period) cycles.
- R6: Each low period of dram_ras_n lasts at least max(ceil(35 ns/T), ceil(65 ns/T) - ceil(25 ns/T)) cycles and at most floor(100 us/T) cycles. An idle open row is closed before that upper limit.
- R7: A column strobe falls only while dram_ras_n is low, and at least ceil(17 ns/T) cycles after dram_ras_n fell.
- R8: A request whose row equals the open row runs without a new fall of dram_ras_n. A request to a different row raises dram_ras_n and then activates the new row.
- R9: For a read, rd_data equals the value on dram_dq_in RD_LAT cycles after the column strobe fell. rd_valid is 1 for exactly one cycle, and dram_oe_n is 0 in the cycle before it.
- R10: While ref_grant is 1, req_ready stays 0. Any open row is closed, and ref_ack is then 1 with dram_ras_n and both column strobes high. After the grant drops, the next activation observes the precharge time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request pending |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in the upper half |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 = bits 15:8 |
| req_ready | output | 1 | Request taken at this clock edge |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 16 | Read data |
| ref_grant | input | 1 | Refresh scheduler asks for the pins |
| ref_ack | output | 1 | Row closed, pins released to refresh |
| dram_addr | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe |
| dram_ucas_n | output | 1 | Column strobe, upper byte |
| dram_lcas_n | output | 1 | Column strobe, lower byte |
| dram_we_n | output | 1 | Write strobe |
| dram_oe_n | output | 1 | Output enable |
| dram_dq_out | output | 16 | Data toward the DRAM |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data from the DRAM |

## Verification
Word writes followed by reads at addresses whose row and column halves differ catch a swapped or stale address phase. Upper-only and lower-only writes over a known word separate a wrong lane decode from a missing lane. Back-to-back accesses to one row against a jump to a different row tell a page hit from a needless reactivation. A long idle gap and a refresh grant that arrives with a request already pending show whether the row is closed on time and whether the host is held off. A behavioural memory in the bench counts strobe cycles at every edge against the precharge, row-low and row-to-column minimums.

// File: rtl/edo_ctrl_pkg.sv
// Shared types and cycle arithmetic for the EDO DRAM controller.
// Assumes timing values are given in picoseconds as positive integers.
package edo_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // row strobe high, bank precharging or closed
        ST_ACT,    // row strobe low, waiting out row-to-column delay
        ST_CSET,   // column address and write strobe set up
        ST_CAS,    // column strobe(s) low
        ST_OPEN,   // row held open, column strobes high
        ST_REF     // pins released to refresh scheduler
    } ctl_state_t;

    // Smallest cycle count covering a minimum, never below one
    function automatic int cyc_ceil(input int ps, input int per);
        int c;
        c = (ps + per - 1) / per;
        return (c < 1) ? 1 : c;
    endfunction

    // Largest cycle count staying within a maximum
    function automatic int cyc_floor(input int ps, input int per);
        return ps / per;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    // Counter width able to hold v
    function automatic int bits_for(input int v);
        int b;
        b = $clog2(v + 1);
        return (b < 1) ? 1 : b;
    endfunction

endpackage

// File: rtl/edo_timing_cnt.sv
// Load-and-drain cycle counter. done is high once the loaded value
// has counted down to zero; holds at zero until the next load.
module edo_timing_cnt #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    // Count down toward zero, reload on request
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/edo_row_track.sv
// Remembers which row is open and compares it to an incoming row.
// Assumes set and clr are never high in the same cycle.
module edo_row_track #(
    parameter int ROW_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set,
    input  logic             clr,
    input  logic [ROW_W-1:0] set_row,
    input  logic [ROW_W-1:0] req_row,
    output logic             open_vld,
    output logic             hit
);
    logic [ROW_W-1:0] open_row;

    // Track the activated row and whether any row is open
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_vld <= 1'b0;
            open_row <= '0;
        end else if (set) begin
            open_vld <= 1'b1;
            open_row <= set_row;
        end else if (clr) begin
            open_vld <= 1'b0;
        end
    end

    assign hit = open_vld && (open_row == req_row);
endmodule

// File: rtl/edo_pin_mux.sv
// Address phase multiplexer and per-byte-lane column strobe decode.
// Reads enable every lane; writes enable only lanes with a set enable.
module edo_pin_mux #(
    parameter int PIN_W = 10,
    parameter int LANES = 2
) (
    input  logic [2*PIN_W-1:0] addr_q,
    input  logic               col_sel,
    input  logic               cas_phase,
    input  logic               is_write,
    input  logic [LANES-1:0]   be_q,
    output logic [PIN_W-1:0]   pin_addr,
    output logic [LANES-1:0]   cas_n
);
    // Row half on activation, column half otherwise
    always_comb begin
        pin_addr = col_sel ? addr_q[PIN_W-1:0] : addr_q[2*PIN_W-1:PIN_W];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign cas_n[l] = !(cas_phase && (!is_write || be_q[l]));
    end
endmodule

// File: rtl/edo_dram_ctrl.sv
// EDO DRAM access controller (top). Turns host requests into row/column
// strobe sequences, keeps the row open for page hits, closes it before
// the row-low limit, and yields to a refresh scheduler on grant.
// Assumes: symmetric row/column width, 16-bit data in two byte lanes,
// RD_LAT small enough that read data is sampled before the next column
// strobe fall (RD_LAT <= C_CAS + 2).
module edo_dram_ctrl
    import edo_ctrl_pkg::*;
#(
    parameter int PIN_W        = 10,
    parameter int CLK_PS       = 20000,
    parameter int T_RP_PS      = 25000,
    parameter int T_RAS_PS     = 35000,
    parameter int T_RAS_MAX_PS = 100000000,
    parameter int T_RCD_PS     = 17000,
    parameter int T_RC_PS      = 65000,
    parameter int T_CAS_PS     = 6000,
    parameter int RD_LAT       = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic               req_we,
    input  logic [2*PIN_W-1:0] req_addr,
    input  logic [15:0]        req_wdata,
    input  logic [1:0]         req_be,
    output logic               req_ready,
    output logic               rd_valid,
    output logic [15:0]        rd_data,
    input  logic               ref_grant,
    output logic               ref_ack,
    output logic [PIN_W-1:0]   dram_addr,
    output logic               dram_ras_n,
    output logic               dram_ucas_n,
    output logic               dram_lcas_n,
    output logic               dram_we_n,
    output logic               dram_oe_n,
    output logic [15:0]        dram_dq_out,
    output logic               dram_dq_oe,
    input  logic [15:0]        dram_dq_in
);
    localparam int C_RP      = cyc_ceil(T_RP_PS, CLK_PS);
    localparam int C_RCD     = cyc_ceil(T_RCD_PS, CLK_PS);
    localparam int C_CAS     = cyc_ceil(T_CAS_PS, CLK_PS);
    localparam int C_RAS_MAX = cyc_floor(T_RAS_MAX_PS, CLK_PS);
    localparam int RAS_HOLD  = max2(cyc_ceil(T_RAS_PS, CLK_PS),
                                    cyc_ceil(T_RC_PS, CLK_PS) - C_RP);
    localparam int RAS_LIMIT = C_RAS_MAX - C_CAS - 3;
    localparam int PH_W      = bits_for(max2(C_RCD, C_CAS));
    localparam int RP_W      = bits_for(C_RP);
    localparam int RC_W      = bits_for(C_RAS_MAX);

    ctl_state_t st, st_nxt;

    logic [2*PIN_W-1:0] addr_q;
    logic [15:0]        wdata_q;
    logic [1:0]         be_q;
    logic               we_q;
    logic [RC_W-1:0]    ras_cnt;
    logic               ph_done, rp_done, ph_load, rp_load;
    logic [PH_W-1:0]    ph_val;
    logic               row_open, row_hit;
    logic               accept_idle, accept_hit, close_row;
    logic               ras_min_ok, near_max, ras_low;
    logic               rd_start, rd_tap;
    logic [1:0]         cas_n;

    // Phase durations: row-to-column delay and column strobe width
    edo_timing_cnt #(.W(PH_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .done(ph_done)
    );

    // Precharge time after the row strobe rises
    edo_timing_cnt #(.W(RP_W)) u_prech (
        .clk(clk), .rst_n(rst_n), .load(rp_load),
        .load_val(RP_W'(C_RP - 1)), .done(rp_done)
    );

    edo_row_track #(.ROW_W(PIN_W)) u_rows (
        .clk(clk), .rst_n(rst_n),
        .set(accept_idle), .clr(close_row),
        .set_row(req_addr[2*PIN_W-1:PIN_W]), .req_row(req_addr[2*PIN_W-1:PIN_W]),
        .open_vld(row_open), .hit(row_hit)
    );

    edo_pin_mux #(.PIN_W(PIN_W), .LANES(2)) u_pins (
        .addr_q(addr_q), .col_sel(st != ST_ACT),
        .cas_phase(st == ST_CAS), .is_write(we_q), .be_q(be_q),
        .pin_addr(dram_addr), .cas_n(cas_n)
    );

    assign ras_low    = (st == ST_ACT) || (st == ST_CSET) || (st == ST_CAS) || (st == ST_OPEN);
    assign ras_min_ok = (ras_cnt >= RC_W'(RAS_HOLD - 1));
    assign near_max   = (ras_cnt >= RC_W'(RAS_LIMIT));

    assign accept_idle = (st == ST_IDLE) && req_valid && !ref_grant && rp_done;
    assign accept_hit  = (st == ST_OPEN) && req_valid && !ref_grant && row_hit && !near_max;
    assign req_ready   = accept_idle || accept_hit;
    assign close_row   = (st == ST_OPEN) && (st_nxt == ST_IDLE);

    // Next-state decision for the strobe sequencer
    always_comb begin
        st_nxt = st;
        unique case (st)
            ST_IDLE: begin
                if (ref_grant && rp_done) st_nxt = ST_REF;
                else if (accept_idle)     st_nxt = ST_ACT;
            end
            ST_ACT:  if (ph_done) st_nxt = ST_CSET;
            ST_CSET: st_nxt = ST_CAS;
            ST_CAS:  if (ph_done) st_nxt = ST_OPEN;
            ST_OPEN: begin
                if (accept_hit) st_nxt = ST_CSET;
                else if (ras_min_ok && (ref_grant || near_max || (req_valid && !row_hit)))
                    st_nxt = ST_IDLE;
            end
            ST_REF:  if (!ref_grant) st_nxt = ST_IDLE;
            default: st_nxt = ST_IDLE;
        endcase
    end

    // Counter loads derived from the transition being taken
    always_comb begin
        ph_load = accept_idle || (st == ST_CSET);
        ph_val  = (st == ST_CSET) ? PH_W'(C_CAS - 1) : PH_W'(C_RCD - 1);
        rp_load = close_row || (st == ST_REF);
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nxt;
    end

    // Capture the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            we_q    <= 1'b0;
        end else if (req_ready) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            we_q    <= req_we;
        end
    end

    // Cycles the row strobe has been low, saturating at the limit
    always_ff @(posedge clk) begin
        if (!rst_n || !ras_low)               ras_cnt <= '0;
        else if (ras_cnt != RC_W'(C_RAS_MAX)) ras_cnt <= ras_cnt + 1'b1;
    end

    // Read sample delay line, started as the column strobe falls
    assign rd_start = (st == ST_CSET) && !we_q;
    if (RD_LAT == 1) begin : g_lat1
        assign rd_tap = rd_start_q;
        logic rd_start_q;
        always_ff @(posedge clk) begin
            if (!rst_n) rd_start_q <= 1'b0;
            else        rd_start_q <= rd_start;
        end
    end else begin : g_latn
        logic [RD_LAT-1:0] pipe;
        // Shift the read marker toward the sample point
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '0;
            else        pipe <= {pipe[RD_LAT-2:0], rd_start};
        end
        assign rd_tap = pipe[RD_LAT-1];
    end

    // Return read data with a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_tap;
            if (rd_tap) rd_data <= dram_dq_in;
        end
    end

    // DRAM pin decode from state and captured request
    always_comb begin
        dram_ras_n  = !ras_low;
        dram_ucas_n = cas_n[1];
        dram_lcas_n = cas_n[0];
        dram_we_n   = !(we_q && ((st == ST_CSET) || (st == ST_CAS)));
        dram_dq_oe  = we_q && ((st == ST_CSET) || (st == ST_CAS));
        dram_oe_n   = !(!we_q && ((st == ST_CSET) || (st == ST_CAS) || (st == ST_OPEN)));
        dram_dq_out = wdata_q;
        ref_ack     = (st == ST_REF);
    end
endmodule

// File: rtl/edo_dram_ctrl_chk.sv
// Protocol checker for edo_dram_ctrl, bound to every instance.
// Observes pins only; keeps its own strobe-duration counters.
module edo_dram_ctrl_chk
    import edo_ctrl_pkg::*;
#(
    parameter int CLK_PS       = 20000,
    parameter int T_RP_PS      = 25000,
    parameter int T_RAS_MAX_PS = 100000000
) (
    input logic clk,
    input logic rst_n,
    input logic req_ready,
    input logic rd_valid,
    input logic ref_grant,
    input logic ref_ack,
    input logic dram_ras_n,
    input logic dram_ucas_n,
    input logic dram_lcas_n,
    input logic dram_we_n,
    input logic dram_oe_n,
    input logic dram_dq_oe
);
    localparam int C_RP    = cyc_ceil(T_RP_PS, CLK_PS);
    localparam int C_MAX   = cyc_floor(T_RAS_MAX_PS, CLK_PS);
    localparam int LW      = bits_for(C_MAX + 1);

    logic [7:0]    hi_cnt;
    logic [LW-1:0] lo_cnt;

    // Count high and low cycles of the row strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_cnt <= 8'hFF;
            lo_cnt <= '0;
        end else begin
            if (dram_ras_n) begin
                lo_cnt <= '0;
                if (hi_cnt != 8'hFF) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt <= '0;
                if (lo_cnt != {LW{1'b1}}) lo_cnt <= lo_cnt + 1'b1;
            end
        end
    end

    AST_PRECHARGE_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ras_n && hi_cnt != 8'h0) |-> (hi_cnt >= 8'(C_RP))); // R5
    AST_RAS_LOW_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= LW'(C_MAX)); // R6
    AST_CAS_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
        (!dram_ucas_n || !dram_lcas_n) |-> !dram_ras_n); // R7
    AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ucas_n && dram_lcas_n) && !dram_we_n) |-> $past(!dram_we_n)); // R4
    AST_NO_DQ_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        dram_dq_oe |-> dram_oe_n); // R4
    AST_READ_OE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(!dram_oe_n)); // R9
    AST_GRANT_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
        ref_grant |-> !req_ready); // R10
    AST_ACK_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (dram_ras_n && dram_ucas_n && dram_lcas_n)); // R10
endmodule

bind edo_dram_ctrl edo_dram_ctrl_chk #(
    .CLK_PS(CLK_PS), .T_RP_PS(T_RP_PS), .T_RAS_MAX_PS(T_RAS_MAX_PS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rd_valid(rd_valid),
    .ref_grant(ref_grant), .ref_ack(ref_ack), .dram_ras_n(dram_ras_n),
    .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_dq_oe(dram_dq_oe)
);

// File: tb/tb_edo_dram_ctrl.sv
`timescale 1ns/1ps
// Directed bench with a behavioural DRAM that checks strobe timing.
module tb_edo_dram_ctrl;
    localparam int PER_PS   = 20000;
    localparam int MAX_PS   = 2000000;
    localparam int LAT      = 2;
    localparam int N_RP     = (25000 + PER_PS - 1) / PER_PS;
    localparam int N_RCD    = (17000 + PER_PS - 1) / PER_PS;
    localparam int N_RASMIN = 2;   // max(ceil(35/20), ceil(65/20)-ceil(25/20))
    localparam int N_MAX    = MAX_PS / PER_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_we = 1'b0;
    logic [19:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = 2'b11;
    logic        req_ready, rd_valid, ref_ack;
    logic [15:0] rd_data;
    logic        ref_grant = 1'b0;
    logic [9:0]  dram_addr;
    logic        dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [15:0] dram_dq_out;
    logic [15:0] dram_dq_in = '0;

    int n_tests = 0, n_fail = 0;
    bit finished = 0;

    edo_dram_ctrl #(.CLK_PS(PER_PS), .T_RAS_MAX_PS(MAX_PS), .RD_LAT(LAT)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rd_valid(rd_valid), .rd_data(rd_data),
        .ref_grant(ref_grant), .ref_ack(ref_ack), .dram_addr(dram_addr),
        .dram_ras_n(dram_ras_n), .dram_ucas_n(dram_ucas_n), .dram_lcas_n(dram_lcas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_out(dram_dq_out),
        .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Behavioural DRAM and strobe-timing monitor
    logic [15:0] mem [int];
    logic [15:0] exp_mem [int];
    int  hi_cnt = 999, lo_cnt = 0, ras_falls = 0;
    logic [9:0] row_l;
    logic p_ras = 1, p_u = 1, p_l = 1, p_we = 1;

    always @(posedge clk) begin
        if (rst_n) begin
            if (!dram_ras_n && p_ras) begin
                chk(hi_cnt >= N_RP, "R5", "precharge cycles", hi_cnt, N_RP);
                row_l = dram_addr;
                ras_falls++;
                lo_cnt = 0;
            end
            if (dram_ras_n && !p_ras)
                chk(lo_cnt >= N_RASMIN && lo_cnt <= N_MAX, "R6", "row low cycles", lo_cnt, N_MAX);
            if (dram_ras_n) begin hi_cnt++; end else begin hi_cnt = 0; lo_cnt++; end
            if ((p_u && p_l) && !(dram_ucas_n && dram_lcas_n)) begin
                chk(!dram_ras_n && (lo_cnt - 1) >= N_RCD, "R7", "row-to-column cycles", lo_cnt - 1, N_RCD);
                if (!dram_we_n) begin
                    int a;
                    logic [15:0] w;
                    a = {row_l, dram_addr};
                    chk(!p_we && dram_dq_oe, "R4", "write strobe setup/drive", {p_we, dram_dq_oe}, 1);
                    w = mem.exists(a) ? mem[a] : 16'h0;
                    if (!dram_ucas_n) w[15:8] = dram_dq_out[15:8];
                    if (!dram_lcas_n) w[7:0]  = dram_dq_out[7:0];
                    mem[a] = w;
                end else begin
                    int a;
                    a = {row_l, dram_addr};
                    chk(!dram_ucas_n && !dram_lcas_n, "R3", "read uses both lanes",
                        {dram_ucas_n, dram_lcas_n}, 0);
                    dram_dq_in <= mem.exists(a) ? mem[a] : 16'h0;
                end
            end
        end
        p_ras = dram_ras_n; p_u = dram_ucas_n; p_l = dram_lcas_n; p_we = dram_we_n;
    end

    // Present a request and hold it until taken
    task automatic host_issue(input bit we, input logic [19:0] a,
                              input logic [15:0] d, input logic [1:0] be);
        @(negedge clk);
        req_valid = 1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 0;
        if (we) begin
            logic [15:0] e;
            e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0;
            if (be[1]) e[15:8] = d[15:8];
            if (be[0]) e[7:0]  = d[7:0];
            exp_mem[int'(a)] = e;
        end
    endtask

    task automatic wait_read(input logic [19:0] a, input string req);
        logic [15:0] e;
        bit seen = 0;
        e = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : 16'h0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (rd_valid) begin seen = 1; break; end
        end
        chk(seen && rd_data == e, req, "read data", rd_data, e);
        @(negedge clk);
        chk(!rd_valid, "R9", "valid is one cycle", rd_valid, 0);
    endtask

    task automatic host_read(input logic [19:0] a, input string req);
        host_issue(0, a, 16'h0, 2'b11);
        wait_read(a, req);
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (4) @(negedge clk);
        chk({dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n} == 5'h1F
            && !dram_dq_oe && !rd_valid && !ref_ack, "R1", "pins in reset",
            {dram_ras_n, dram_ucas_n, dram_lcas_n, dram_we_n, dram_oe_n, dram_dq_oe}, 6'h3E);
        rst_n = 1;
        @(negedge clk);
        chk(dram_ras_n && dram_ucas_n && dram_lcas_n && !rd_valid, "R1", "pins after reset",
            {dram_ras_n, dram_ucas_n, dram_lcas_n}, 7);
    endtask

    task automatic t_word();
        host_issue(1, 20'h12345, 16'hA5C3, 2'b11);
        host_issue(1, 20'h34512, 16'h0F1E, 2'b11);
        host_read(20'h12345, "R2");
        host_read(20'h34512, "R2");
    endtask

    task automatic t_bytes();
        host_issue(1, 20'h0ABCD, 16'h1111, 2'b11);
        host_issue(1, 20'h0ABCD, 16'hAB99, 2'b10);
        host_read(20'h0ABCD, "R3");
        host_issue(1, 20'h0ABCD, 16'h77CD, 2'b01);
        host_read(20'h0ABCD, "R3");
    endtask

    task automatic t_page_hit();
        int f0;
        host_read(20'h15401, "R9");
        f0 = ras_falls;
        host_issue(1, 20'h15402, 16'h5A5A, 2'b11);
        host_read(20'h15402, "R8");
        chk(ras_falls == f0, "R8", "no activation on hit", ras_falls, f0);
    endtask

    task automatic t_page_miss();
        int f0;
        f0 = ras_falls;
        host_read(20'hAA803, "R8");
        chk(ras_falls == f0 + 1, "R8", "one activation on miss", ras_falls, f0 + 1);
    endtask

    task automatic t_ras_max();
        host_issue(1, 20'h00777, 16'hBEEF, 2'b11);
        repeat (N_MAX + 20) @(negedge clk);
        chk(dram_ras_n, "R6", "idle row closed", dram_ras_n, 1);
        host_read(20'h00777, "R6");
    endtask

    task automatic t_refresh();
        int f0;
        bit seen = 0, stalled = 1;
        host_read(20'h31011, "R10");
        f0 = ras_falls;
        @(negedge clk);
        ref_grant = 1;
        req_valid = 1; req_we = 0; req_addr = 20'h31012; req_be = 2'b11;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (req_ready) stalled = 0;
            if (ref_ack) begin seen = 1; break; end
        end
        chk(seen && dram_ras_n && dram_ucas_n && dram_lcas_n, "R10", "ack with pins high",
            {seen, dram_ras_n, dram_ucas_n, dram_lcas_n}, 15);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (req_ready) stalled = 0;
        end
        chk(stalled, "R10", "host stalled under grant", stalled, 1);
        ref_grant = 0;
        #1;
        while (!req_ready) begin @(negedge clk); #1; end
        @(negedge clk);
        req_valid = 0;
        wait_read(20'h31012, "R10");
        chk(ras_falls == f0 + 1, "R10", "row reopened after grant", ras_falls, f0 + 1);
    endtask

    initial begin
        #(200000 * 20);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_word();
        t_bytes();
        t_page_hit();
        t_page_miss();
        t_ras_max();
        t_refresh();
        repeat (5) @(negedge clk);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule